// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the cycle-level front end of a flow-through synchronous SRAM with a shared data path. An access starts when one of two address strobes is seen at a rising clock edge: a processor strobe or a controller strobe. Each has its own priority and masking rules. The block samples three chip enables and latches the address. A two-bit burst offset counter then walks the low address bits in linear or interleaved order, or holds them still. The block decodes a global write, a byte-write enable and four byte enables into per-lane write strobes for a 36-bit word. That word is made of four 9-bit lanes, each holding 8 data bits and 1 parity bit.

Read data is flow-through. It comes combinationally from the registered address, so it is visible in the cycle after the edge that set that address. The shared bus is modelled as the split form used at a pad ring: `dq_in`, `dq_out` and `dq_oe`. The output enable gates `dq_oe` without the clock. Any write seen on the pins forces the bus off, whatever the output enable says. A sleep input takes two edges to take effect and two edges to be released. While asleep, all accesses are ignored and the stored contents are kept.

Top module: `sram_burst_ctrl`

## Requirements
- R1: The device is selected only when `cen1_n`=0, `cen2`=1 and `cen3_n`=0.
  - An accepted strobe while not selected ends any burst and turns the bus off from the next cycle.
  - Until a new start, no write takes place.
- R2: `pstrb_n`=0 with `cen1_n`=0 while selected starts a read at `addr`. At that edge nothing is written, whatever the write inputs are.
- R3: `pstrb_n` is ignored when `cen1_n`=1. With `cstrb_n`=1 the cycle is treated as a burst continue or suspend.
- R4: `cstrb_n` is ignored while `pstrb_n`=0 and `cen1_n`=0.
- R5: When the controller strobe is accepted and the device is selected, the access starts at `addr`.
  - If the write inputs indicate a write, the word is written at that same edge.
  - Otherwise the access is a read.
- R6: The write inputs are decoded as follows.
  - `gwr_n`=0 writes all four lanes.
  - With `gwr_n`=1 and `bwr_n`=0, each lane i with `ben_n[i]`=0 is written.
  - Lane i is bits [9i+8:9i] of the word. Bit 9i+8 is its parity bit.
  - `gwr_n`=1 with `bwr_n`=1, or `bwr_n`=0 with all `ben_n` high, is a read.
- R7: With no accepted strobe and a burst active, the access continues.
  - `adv_n`=0 moves to the next burst offset. A write in that cycle targets the new address.
  - `adv_n`=1 suspends the burst at the current address.
- R8: The burst order depends on `ilv_mode`. The upper address bits stay fixed.
  - `ilv_mode`=1: the offset is start XOR count.
  - `ilv_mode`=0: the offset is (start + count) mod 4.
- R9: Read data appears on `dq_out` in the cycle after the edge that set the address.
  - `dq_oe`=1 only when the last access was a read, `oe_n`=0 and no write is indicated.
  - `oe_n` acts without the clock.
- R10: While the write inputs indicate any write, including a single-lane write, `dq_oe` is 0 regardless of `oe_n`.
- R11: Sleep takes effect and is released on a fixed schedule.
  - The block is asleep from the second rising edge that samples `sleep`=1.
  - It wakes at the second edge that samples `sleep`=0.
  - While asleep, strobes and writes are ignored, `dq_oe`=0 and the contents are kept.
  - A burst is not resumed after wake-up.
- R12: After reset, `dq_oe` is 0 and no burst is active. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address, low two bits feed the burst counter |
| cen1_n | input | 1 | Chip enable 1, active low, also gates the processor strobe |
| cen2 | input | 1 | Chip enable 2, active high |
| cen3_n | input | 1 | Chip enable 3, active low |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| ben_n | input | 4 | Per-lane byte enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep | input | 1 | Sleep request, active high |
| dq_in | input | 36 | Write data from the bus |
| dq_out | output | 36 | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
Two functions can land in the same cycle: the forced read of a processor-strobe start, and the tri-state override of a detected write.

The bench first leaves a read driving the bus. It then presents the processor strobe with the global write low, new data on `dq_in` and `oe_n` low. Within that cycle it checks that the bus is off. In the following cycle it checks that the old word is being read back. A partial-lane write on a suspend cycle is judged in the same way: the bus must go off while `oe_n` is low, and the merged word must be read back afterwards.

// File: rtl/sbc_pkg.sv
// Package: shared sizes for the burst SRAM controller.
// Assumes four lanes of eight data bits plus one parity bit each.
package sbc_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int LANE_W = BYTE_W + 1;
    localparam int WORD_W = LANES * LANE_W;
    localparam int OFF_W  = 2;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/sbc_burst_ctr.sv
// Module: burst offset counter.
// Captures a start offset on load and counts accesses on step.
// Maps the count to an offset in linear (add) or interleaved (xor) order.
// Gives both the current offset and the one a step would reach.
// Assumes the order input is steady while a burst is stepping.
module sbc_burst_ctr #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_off,
    input  logic          step,
    input  logic          ilv,
    output logic [CW-1:0] cur_off,
    output logic [CW-1:0] nxt_off
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] base_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;

    // Purpose: count of the access after this one.
    assign cnt_nx = cnt_q + ONE;

    // Purpose: map counts to offsets in the selected order.
    always_comb begin
        if (ilv) begin
            cur_off = base_q ^ cnt_q;
            nxt_off = base_q ^ cnt_nx;
        end else begin
            cur_off = base_q + cnt_q;
            nxt_off = base_q + cnt_nx;
        end
    end

    // Purpose: hold the start offset and the access count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= load_off;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_nx;
        end
    end

    // R7: every step lands on a different offset
    p_step_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cur_off != $past(cur_off)));
endmodule

// File: rtl/sbc_wr_decode.sv
// Module: write input decoder.
// Turns the global write, the byte-write enable and the per-lane enables
// (all active low) into active-high lane write requests.
// Also gives a flag that any lane is requested.
module sbc_wr_decode
    import sbc_pkg::*;
(
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] ben_n,
    output logic [LANES-1:0] lane_req,
    output logic             we_any
);
    // Purpose: global write wins, then per-lane enables under byte-write.
    always_comb begin
        if (!gwr_n)      lane_req = '1;
        else if (!bwr_n) lane_req = ~ben_n;
        else             lane_req = '0;
        we_any = |lane_req;
    end
endmodule

// File: rtl/sbc_sleep_ctl.sv
// Module: sleep sequencer.
// Asleep from the second edge that samples sleep high.
// Awake again from the second edge that samples it low.
// Assumes sleep is already synchronous to clk.
module sbc_sleep_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic asleep
);
    logic stage1_q;
    logic stage2_q;

    // Purpose: two-edge delay line on the sleep request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else begin
            stage1_q <= sleep;
            stage2_q <= stage1_q;
        end
    end

    assign asleep = stage2_q;

    // R11: entry only after sleep was sampled high two edges earlier
    p_enter_two_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(sleep, 2));
endmodule

// File: rtl/sbc_array.sv
// Module: behavioural word array built from four 9-bit lanes.
// Write is synchronous with per-lane enables.
// Read is combinational from the read address (flow-through).
// Assumes DEPTH is a power of two. Contents are not reset.
module sbc_array
    import sbc_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [LANES-1:0]  lane_we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Purpose: store this lane when its strobe is set.
        always_ff @(posedge clk) begin
            if (lane_we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/sram_burst_ctrl.sv
// Module: top of the burst SRAM access controller.
// Resolves the two strobes and chip selects into start, deselect and
// continue cycles, and keeps the upper address and burst state.
// Drives the lane write strobes and the bus enable.
// Assumes AW >= 3 and that the host keeps strobes inactive for two
// cycles after a sleep exit.
module sram_burst_ctrl
    import sbc_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              cen1_n,
    input  logic              cen2,
    input  logic              cen3_n,
    input  logic              pstrb_n,
    input  logic              cstrb_n,
    input  logic              adv_n,
    input  logic              gwr_n,
    input  logic              bwr_n,
    input  logic [LANES-1:0]  ben_n,
    input  logic              oe_n,
    input  logic              ilv_mode,
    input  logic              sleep,
    input  logic [WORD_W-1:0] dq_in,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int HI_W = AW - OFF_W;

    logic [HI_W-1:0]  hi_q;
    logic             active_q;
    logic             rdv_q;
    logic             asleep;
    logic [LANES-1:0] lane_req;
    logic [LANES-1:0] lane_we;
    logic             we_any;
    logic [OFF_W-1:0] cur_off;
    logic [OFF_W-1:0] nxt_off;
    logic             sel, p_req, c_req, strobe, start, desel, cont, wr_go;
    logic [AW-1:0]    waddr;
    logic [AW-1:0]    raddr;

    sbc_wr_decode u_dec (
        .gwr_n    (gwr_n),
        .bwr_n    (bwr_n),
        .ben_n    (ben_n),
        .lane_req (lane_req),
        .we_any   (we_any)
    );

    sbc_sleep_ctl u_sleep (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep  (sleep),
        .asleep (asleep)
    );

    // Purpose: classify this edge as start, deselect or continue.
    always_comb begin
        sel    = !cen1_n && cen2 && !cen3_n;
        p_req  = !asleep && !pstrb_n && !cen1_n;
        c_req  = !asleep && !cstrb_n && !(!pstrb_n && !cen1_n);
        strobe = p_req || c_req;
        start  = strobe && sel;
        desel  = strobe && !sel;
        cont   = !asleep && !strobe && active_q;
        wr_go  = we_any && ((c_req && sel) || cont);
        lane_we = wr_go ? lane_req : '0;
    end

    sbc_burst_ctr #(.CW(OFF_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_off (addr[OFF_W-1:0]),
        .step     (cont && !adv_n),
        .ilv      (ilv_mode == ORDER_INTERLEAVE),
        .cur_off  (cur_off),
        .nxt_off  (nxt_off)
    );

    // Purpose: write target; a controller start writes the pin address.
    always_comb begin
        if (c_req) waddr = addr;
        else       waddr = {hi_q, (adv_n ? cur_off : nxt_off)};
        raddr = {hi_q, cur_off};
    end

    sbc_array #(.DEPTH(DEPTH)) u_arr (
        .clk     (clk),
        .lane_we (lane_we),
        .waddr   (waddr),
        .wdata   (dq_in),
        .raddr   (raddr),
        .rdata   (dq_out)
    );

    // Purpose: burst activity, read-valid flag and upper address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            rdv_q    <= 1'b0;
            hi_q     <= '0;
        end else if (asleep) begin
            active_q <= 1'b0;
            rdv_q    <= 1'b0;
        end else if (start) begin
            active_q <= 1'b1;
            hi_q     <= addr[AW-1:OFF_W];
            rdv_q    <= !(c_req && we_any);
        end else if (desel) begin
            active_q <= 1'b0;
            rdv_q    <= 1'b0;
        end else if (cont) begin
            rdv_q    <= !we_any;
        end
    end

    // Purpose: bus drive, gated without the clock by output enable.
    assign dq_oe = rdv_q && !oe_n && !we_any && !asleep;

    // R2: a processor-strobe start always leaves a read pending
    p_pstart_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && sel) |=> rdv_q);
    // R1: a strobe while unselected leaves the bus undriven next cycle
    p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !sel) |=> !dq_oe);
    // R10: detected write keeps the bus off
    p_write_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we_any |-> !dq_oe);
    // R11: no drive while asleep
    p_sleep_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !dq_oe);
    // R4: an accepted processor strobe never writes on its own edge
    p_cmask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstrb_n && !cen1_n) |-> (lane_we == '0));
endmodule

// File: tb/sram_burst_ctrl_tb_top.sv
// Bench: directed scenarios for the burst SRAM controller, one task each.
module sram_burst_ctrl_tb_top;
    localparam int DEPTH = 64;
    localparam int AW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          cen1_n, cen2, cen3_n, pstrb_n, cstrb_n, adv_n;
    logic          gwr_n, bwr_n, oe_n, ilv_mode, sleep;
    logic [3:0]    ben_n;
    logic [35:0]   dq_in;
    logic [35:0]   dq_out;
    logic          dq_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sram_burst_ctrl #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cen1_n(cen1_n), .cen2(cen2),
        .cen3_n(cen3_n), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n),
        .gwr_n(gwr_n), .bwr_n(bwr_n), .ben_n(ben_n), .oe_n(oe_n),
        .ilv_mode(ilv_mode), .sleep(sleep), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe)
    );

    function automatic logic [35:0] mk(input int a, input int s);
        mk = {4'(a ^ s), 8'(a), 8'(s + 60), 8'(a * 7 + s), 8'(8'hC3 ^ 8'(a))};
    endfunction

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        pstrb_n = 1; cstrb_n = 1; adv_n = 1; gwr_n = 1; bwr_n = 1;
        ben_n = 4'hF; cen1_n = 0; cen2 = 1; cen3_n = 0; oe_n = 0; dq_in = '0;
    endtask

    task automatic edge1();
        @(posedge clk); #1;
    endtask

    task automatic cwrite(input int a, input logic [35:0] d);
        addr = AW'(a); cstrb_n = 0; gwr_n = 0; dq_in = d;
        edge1(); idle();
    endtask

    task automatic pstart(input int a);
        addr = AW'(a); pstrb_n = 0;
        edge1(); idle();
    endtask

    task automatic readchk(input int a, input logic [35:0] exp, input string tag);
        pstart(a); #1;
        chk(tag, dq_out, exp);
        chk(tag, {35'd0, dq_oe}, 36'd1);
    endtask

    task automatic t_reset();
        #1; chk("R12 reset bus off", {35'd0, dq_oe}, 36'd0);
    endtask

    task automatic t_cwrite_read();
        cwrite(5, mk(5, 1)); #1;
        chk("R9 bus off after write", {35'd0, dq_oe}, 36'd0);
        readchk(5, mk(5, 1), "R5 controller write then read");
        addr = AW'(5); cstrb_n = 0; edge1(); idle(); #1;
        chk("R5 controller-strobe read data", dq_out, mk(5, 1));
        chk("R5 controller-strobe read drive", {35'd0, dq_oe}, 36'd1);
        oe_n = 1; #1;
        chk("R9 oe_n high no clock", {35'd0, dq_oe}, 36'd0);
        oe_n = 0; #1;
        chk("R9 oe_n low no clock", {35'd0, dq_oe}, 36'd1);
    endtask

    task automatic t_forced_read();
        logic [35:0] e;
        cwrite(8, mk(8, 2));
        readchk(8, mk(8, 2), "R9 read before forced read");
        addr = AW'(8); pstrb_n = 0; gwr_n = 0; dq_in = mk(8, 9); #1;
        chk("R10 global write bus off", {35'd0, dq_oe}, 36'd0);
        edge1(); idle(); #1;
        chk("R2 forced read data", dq_out, mk(8, 2));
        adv_n = 1; bwr_n = 0; ben_n = 4'b1101; dq_in = mk(8, 5); #1;
        chk("R10 lane write bus off", {35'd0, dq_oe}, 36'd0);
        edge1(); idle(); edge1(); #1;
        e = mk(8, 2); e[17:9] = mk(8, 5)[17:9];
        chk("R6 lane1 merge", dq_out, e);
        bwr_n = 0; ben_n = 4'hF; dq_in = '1; edge1(); idle(); #1;
        chk("R6 all enables high is read", dq_out, e);
        gwr_n = 1; bwr_n = 1; ben_n = 4'h0; dq_in = '1; edge1(); idle(); #1;
        chk("R6 byte-write off is read", dq_out, e);
        chk("R6 read drives", {35'd0, dq_oe}, 36'd1);
    endtask

    task automatic burst_read(input int start, input int ilv, input string tag);
        int seq[4];
        ilv_mode = 1'(ilv);
        for (int i = 0; i < 4; i++)
            seq[i] = ilv != 0 ? ((start & 3) ^ i) : (((start & 3) + i) & 3);
        pstart(start); #1;
        chk({tag, " first"}, dq_out, mk(16 + seq[0], 3));
        adv_n = 1; edge1(); idle(); #1;
        chk("R7 suspend holds", dq_out, mk(16 + seq[0], 3));
        for (int i = 1; i < 4; i++) begin
            adv_n = 0; edge1(); idle(); #1;
            chk(tag, dq_out, mk(16 + seq[i], 3));
        end
        adv_n = 0; edge1(); idle(); #1;
        chk({tag, " wrap"}, dq_out, mk(16 + seq[0], 3));
    endtask

    task automatic t_burst();
        for (int a = 16; a < 20; a++) cwrite(a, mk(a, 3));
        burst_read(17, 0, "R8 linear");
        burst_read(17, 1, "R8 interleave");
        burst_read(18, 0, "R8 linear from 2");
    endtask

    task automatic t_burst_write();
        int order[4] = '{22, 23, 20, 21};
        ilv_mode = 1;
        cwrite(22, mk(22, 4));
        for (int i = 1; i < 4; i++) begin
            adv_n = 0; gwr_n = 0; dq_in = mk(order[i], 4);
            edge1(); idle();
        end
        for (int i = 0; i < 4; i++)
            readchk(order[i], mk(order[i], 4), "R7 burst write target");
    endtask

    task automatic t_masks();
        cwrite(30, mk(30, 6));
        addr = AW'(30); pstrb_n = 0; cstrb_n = 0; gwr_n = 0; dq_in = mk(30, 7);
        edge1(); idle(); #1;
        chk("R4 controller strobe masked", dq_out, mk(30, 6));
        ilv_mode = 0;
        pstart(16);
        addr = AW'(30); pstrb_n = 0; cen1_n = 1; adv_n = 0;
        edge1(); idle(); #1;
        chk("R3 processor strobe ignored, burst advanced", dq_out, mk(17, 3));
    endtask

    task automatic t_deselect();
        cwrite(31, mk(31, 8));
        readchk(16, mk(16, 3), "R1 read before deselect");
        addr = AW'(30); pstrb_n = 0; cen2 = 0; edge1(); idle(); #1;
        chk("R1 deselect bus off", {35'd0, dq_oe}, 36'd0);
        gwr_n = 0; dq_in = '1; edge1(); idle();
        readchk(16, mk(16, 3), "R1 no write after deselect");
        addr = AW'(31); cstrb_n = 0; cen3_n = 1; gwr_n = 0; dq_in = '1;
        edge1(); idle();
        readchk(31, mk(31, 8), "R1 unselected controller write dropped");
    endtask

    task automatic t_sleep();
        cwrite(40, mk(40, 1));
        readchk(40, mk(40, 1), "R11 read before sleep");
        sleep = 1; edge1(); #1;
        chk("R11 awake after one edge", {35'd0, dq_oe}, 36'd1);
        edge1(); #1;
        chk("R11 asleep after two edges", {35'd0, dq_oe}, 36'd0);
        cwrite(40, mk(40, 2));
        cwrite(41, mk(41, 2));
        sleep = 0; edge1(); edge1(); edge1();
        gwr_n = 0; dq_in = '1; edge1(); idle();
        readchk(40, mk(40, 1), "R11 contents kept, writes ignored");
    endtask

    initial begin : watchdog
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; sleep = 0; ilv_mode = 0; addr = '0; idle();
        repeat (3) edge1();
        rst_n = 1;
        t_reset();
        t_cwrite_read();
        t_forced_read();
        t_burst();
        t_burst_write();
        t_masks();
        t_deselect();
        t_sleep();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule